// File: doc/BRIEF.md
# Synchronous-Clock Serial Frame Transmitter

This block turns words handed to it by a host into asynchronous serial frames on a single transmit line. A word is written into a one-deep holding register. On a later half-bit tick the word moves into a shift register, and the frame goes out. A frame is one low start bit, then 8 or 9 data bits sent least significant bit first, then a high stop period of 1, 1.5 or 2 bit times. When parity is enabled, the last data position carries a computed parity bit instead of a data bit. Every bit cell lasts exactly two half-bit ticks, and all frame timing counts those ticks. That is how 1.5 stop bits come out exact.

A second output can drive a serial clock for a shift-register peripheral on the far end. The clock pulses only while data bits are on the line, with one pulse per bit cell. The idle level is set by the polarity input. The phase input chooses whether the pulse sits in the first half or the second half of the cell. The pulse on the final data bit is optional. Two flags report progress: holding register empty, and transmission complete. Each flag can raise the shared interrupt request when its enable is set. The baud tick comes from outside.

Top module: `uart_sync_tx`

## Requirements
- R1: Out of reset, and whenever no frame is in flight, `tx` is 1 and `ck` equals `ck_pol`. Reset sets `txe` to 1 and `tc` to 1.
- R2: A frame starts on the first `half_tick` at which a word is pending and `tx_en` is 1. Every bit cell spans two `half_tick` periods. The frame is a 0 start cell, followed by 8 data cells (`word9`=0, bit 8 of the written word ignored) or 9 data cells (`word9`=1), sent bit 0 first.
- R3: After the data cells, `tx` stays 1 for 2, 3 or 4 `half_tick` periods when `stop_sel` is 00, 01 or 1x. This gives 1, 1.5 or 2 stop bits.
- R4: With `par_en`=1, the last data cell (bit 7 or bit 8) carries parity instead of the written bit. The parity is computed over all earlier data cells. With `par_odd`=0 the total count of ones in the data cells is even. With `par_odd`=1 it is odd.
- R5: With `ck_en`=1, `ck` leaves `ck_pol` only during data cells. With `ck_pha`=0 it is inverted in the second half of each cell. With `ck_pha`=1 it is inverted in the first half. It equals `ck_pol` during the start and stop cells.
- R6: The last data cell gets a clock pulse only when `ck_last`=1. Otherwise `ck` stays at `ck_pol` through that cell.
- R7: A write clears `txe` on the next cycle. `txe` returns to 1 on the tick at which the pending word enters the shift register.
- R8: `tc` clears on a write. It sets on the tick that ends the stop period when no word is pending. When a word is pending, its start cell follows the stop period with no idle gap, and `tc` stays 0.
- R9: `irq` is 1 exactly when (`txe_ie` and `txe`) or (`tc_ie` and `tc`).
- R10: While `tx_en` is 0, no frame starts, `tx` stays 1, and a written word stays pending with `txe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Allows new frames to start |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 9 | Word to send |
| half_tick | input | 1 | One-cycle pulse at twice the bit rate |
| word9 | input | 1 | 9 data cells when 1, 8 when 0 |
| par_en | input | 1 | Replace last data cell with parity |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| stop_sel | input | 2 | Stop length: 00 one bit, 01 one and a half, 1x two |
| ck_en | input | 1 | Enables pulses on `ck` |
| ck_pol | input | 1 | Idle level of `ck` |
| ck_pha | input | 1 | 1: pulse in first half of cell, 0: in second half |
| ck_last | input | 1 | Pulse on the last data cell |
| txe_ie | input | 1 | Interrupt enable for `txe` |
| tc_ie | input | 1 | Interrupt enable for `tc` |
| tx | output | 1 | Serial data line |
| ck | output | 1 | Synchronous clock line |
| txe | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall on the same tick: the end of a stop period and the load of a pending word into the shift register. This is provoked by writing a second word during the start cell of a frame, so that it is already waiting when the stop period runs out. The bench then checks four things: the next half-bit slot is a start cell, `tc` never rises, `txe` returns to 1 at that slot, and the second frame matches its model bit for bit. A write that lands on the same cycle as a tick, while the line is idle, is also covered. That write must wait for the following tick before its frame starts.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic       word9;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop_sel;
    } frame_cfg_t;

    typedef struct packed {
        logic en;
        logic pol;
        logic pha;
        logic last;
    } ck_cfg_t;

    localparam int unsigned STOP_CNT_W = 3;

    // stop period length in half-bit ticks
    function automatic logic [STOP_CNT_W-1:0] stop_halves(input logic [1:0] sel);
        logic [STOP_CNT_W-1:0] n;
        case (sel)
            2'b00:   n = 3'd2;
            2'b01:   n = 3'd3;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/utx_holding.sv
module utx_holding #(
    parameter int unsigned WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    output logic [WORD_W-1:0] hold_data,
    output logic              hold_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_data  <= '0;
            hold_valid <= 1'b0;
        end else if (wr_en) begin
            // a write wins over a simultaneous take
            hold_data  <= wr_data;
            hold_valid <= 1'b1;
        end else if (take) begin
            hold_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import uart_tx_pkg::*;
#(
    parameter int unsigned WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              half_tick,
    input  logic              tx_en,
    input  logic              hold_valid,
    input  logic [WORD_W-1:0] hold_data,
    input  frame_cfg_t        cfg,
    output logic              take,
    output logic              done,
    output logic              tx,
    output logic              in_data,
    output logic              second_half,
    output logic              last_bit
);

    localparam int unsigned IDX_W = $clog2(WORD_W);
    localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(WORD_W - 1);
    localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(WORD_W - 2);

    tx_state_e             st;
    logic                  half;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W-1:0]      last_idx;
    logic [WORD_W-1:0]     shreg;
    logic [STOP_CNT_W-1:0] stop_left;
    logic [1:0]            lat_stop;
    logic                  stop_end;

    function automatic logic [WORD_W-1:0] build_word(input logic [WORD_W-1:0] d,
                                                      input frame_cfg_t c);
        logic [WORD_W-1:0] w;
        int unsigned       pos;
        logic              p;
        w = d;
        if (!c.word9)
            w[WORD_W-1] = 1'b0;
        pos = c.word9 ? WORD_W - 1 : WORD_W - 2;
        if (c.par_en) begin
            p = c.par_odd;
            for (int unsigned i = 0; i < WORD_W; i++)
                if (i < pos)
                    p = p ^ w[i];
            w[pos] = p;
        end
        return w;
    endfunction

    assign stop_end = (st == ST_STOP) && (stop_left == STOP_CNT_W'(1));
    assign take     = half_tick && hold_valid && tx_en && ((st == ST_IDLE) || stop_end);
    assign done     = half_tick && stop_end && !hold_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            half      <= 1'b0;
            idx       <= '0;
            last_idx  <= LAST_SHORT;
            shreg     <= '0;
            stop_left <= '0;
            lat_stop  <= 2'b00;
        end else if (half_tick) begin
            if (take) begin
                st       <= ST_START;
                half     <= 1'b0;
                shreg    <= build_word(hold_data, cfg);
                last_idx <= cfg.word9 ? LAST_LONG : LAST_SHORT;
                lat_stop <= cfg.stop_sel;
            end else begin
                case (st)
                    ST_START: begin
                        if (half) begin
                            st   <= ST_DATA;
                            half <= 1'b0;
                            idx  <= '0;
                        end else begin
                            half <= 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (half) begin
                            half  <= 1'b0;
                            shreg <= shreg >> 1;
                            if (idx == last_idx) begin
                                st        <= ST_STOP;
                                stop_left <= stop_halves(lat_stop);
                            end else begin
                                idx <= idx + IDX_W'(1);
                            end
                        end else begin
                            half <= 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (stop_end)
                            st <= ST_IDLE;
                        else
                            stop_left <= stop_left - STOP_CNT_W'(1);
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (st)
            ST_START: tx = 1'b0;
            ST_DATA:  tx = shreg[0];
            default:  tx = 1'b1;
        endcase
    end

    assign in_data     = (st == ST_DATA);
    assign second_half = half;
    assign last_bit    = in_data && (idx == last_idx);

endmodule

// File: rtl/utx_clkgen.sv
module utx_clkgen
    import uart_tx_pkg::*;
(
    input  logic    in_data,
    input  logic    second_half,
    input  logic    last_bit,
    input  ck_cfg_t cfg,
    output logic    ck
);

    logic pulse_cell;

    assign pulse_cell = cfg.en && in_data && (!last_bit || cfg.last);

    always_comb begin
        if (pulse_cell)
            ck = cfg.pol ^ (cfg.pha ? !second_half : second_half);
        else
            ck = cfg.pol;
    end

endmodule

// File: rtl/uart_sync_tx.sv
module uart_sync_tx
    import uart_tx_pkg::*;
#(
    parameter int unsigned WORD_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              half_tick,
    input  logic              word9,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        stop_sel,
    input  logic              ck_en,
    input  logic              ck_pol,
    input  logic              ck_pha,
    input  logic              ck_last,
    input  logic              txe_ie,
    input  logic              tc_ie,
    output logic              tx,
    output logic              ck,
    output logic              txe,
    output logic              tc,
    output logic              irq
);

    frame_cfg_t        fcfg;
    ck_cfg_t           ccfg;
    logic [WORD_W-1:0] hold_data;
    logic              hold_valid;
    logic              take;
    logic              done;
    logic              in_data;
    logic              second_half;
    logic              last_bit;
    logic              tc_q;

    assign fcfg = '{word9: word9, par_en: par_en, par_odd: par_odd, stop_sel: stop_sel};
    assign ccfg = '{en: ck_en, pol: ck_pol, pha: ck_pha, last: ck_last};

    utx_holding #(.WORD_W(WORD_W)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (take),
        .hold_data  (hold_data),
        .hold_valid (hold_valid)
    );

    utx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .half_tick   (half_tick),
        .tx_en       (tx_en),
        .hold_valid  (hold_valid),
        .hold_data   (hold_data),
        .cfg         (fcfg),
        .take        (take),
        .done        (done),
        .tx          (tx),
        .in_data     (in_data),
        .second_half (second_half),
        .last_bit    (last_bit)
    );

    utx_clkgen u_ck (
        .in_data     (in_data),
        .second_half (second_half),
        .last_bit    (last_bit),
        .cfg         (ccfg),
        .ck          (ck)
    );

    always_ff @(posedge clk) begin
        if (rst)
            tc_q <= 1'b1;
        else if (wr_en)
            tc_q <= 1'b0;
        else if (done)
            tc_q <= 1'b1;
    end

    assign tc  = tc_q;
    assign txe = !hold_valid;
    assign irq = (txe_ie && txe) || (tc_ie && tc_q);

endmodule

// File: rtl/utx_checker.sv
module utx_checker (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic tx,
    input logic ck,
    input logic ck_pol,
    input logic txe,
    input logic tc,
    input logic tc_ie,
    input logic irq
);

    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        tc |-> tx);

    a_r5_ck_rests_at_pol: assert property (@(posedge clk) disable iff (rst)
        tc |-> (ck == ck_pol));

    a_r3_stop_high_before_done: assert property (@(posedge clk) disable iff (rst)
        $rose(tc) |-> $past(tx));

    a_r7_write_clears_txe: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !txe);

    a_r8_write_clears_tc: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !tc);

    a_r8_complete_means_empty: assert property (@(posedge clk) disable iff (rst)
        tc |-> txe);

    a_r9_complete_raises_irq: assert property (@(posedge clk) disable iff (rst)
        (tc && tc_ie) |-> irq);

endmodule

bind uart_sync_tx utx_checker i_utx_checker (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .tx     (tx),
    .ck     (ck),
    .ck_pol (ck_pol),
    .txe    (txe),
    .tc     (tc),
    .tc_ie  (tc_ie),
    .irq    (irq)
);

// File: tb/test_uart_sync_tx.sv
module test_uart_sync_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b1;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       half_tick = 1'b0;
    logic       word9 = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic [1:0] stop_sel = 2'b00;
    logic       ck_en = 1'b0, ck_pol = 1'b0, ck_pha = 1'b0, ck_last = 1'b0;
    logic       txe_ie = 1'b0, tc_ie = 1'b0;
    logic       tx, ck, txe, tc, irq;

    int checks = 0;
    int fails  = 0;
    logic [1:0] tcnt = 2'd0;

    always #4 clk = ~clk;

    always @(negedge clk) begin
        tcnt      <= tcnt + 2'd1;
        half_tick <= (tcnt == 2'd3);
    end

    uart_sync_tx i_uart_sync_tx (
        .clk(clk), .rst(rst), .tx_en(tx_en), .wr_en(wr_en), .wr_data(wr_data),
        .half_tick(half_tick), .word9(word9), .par_en(par_en), .par_odd(par_odd),
        .stop_sel(stop_sel), .ck_en(ck_en), .ck_pol(ck_pol), .ck_pha(ck_pha),
        .ck_last(ck_last), .txe_ie(txe_ie), .tc_ie(tc_ie),
        .tx(tx), .ck(ck), .txe(txe), .tc(tc), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_bits(input logic [8:0] w);
        logic [8:0] b = w;
        int nb = word9 ? 9 : 8;
        logic p;
        if (!word9) b[8] = 1'b0;
        if (par_en) begin
            p = par_odd;
            for (int k = 0; k < nb - 1; k++) p = p ^ b[k];
            b[nb-1] = p;
        end
        return b;
    endfunction

    function automatic int exp_stop();
        return (stop_sel == 2'b00) ? 2 : (stop_sel == 2'b01) ? 3 : 4;
    endfunction

    function automatic logic exp_irq();
        return (txe_ie && txe) || (tc_ie && tc);
    endfunction

    task automatic wait_tick();
        do @(posedge clk); while (!half_tick);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [8:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_data = w;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_frame(input logic [8:0] w, input bit has_next,
                             input logic [8:0] nxt, input bit final_idle);
        logic [8:0] b = exp_bits(w);
        int nb = word9 ? 9 : 8;
        int total = 2 + 2 * nb + exp_stop();
        for (int s = 0; s < total; s++) begin
            logic etx, eck;
            int h = s % 2;
            wait_tick();
            if (s < 2) begin
                etx = 1'b0; eck = ck_pol;
            end else if (s < 2 + 2 * nb) begin
                int k = (s - 2) / 2;
                etx = b[k];
                if (ck_en && (k < nb - 1 || ck_last))
                    eck = ck_pol ^ (ck_pha ? (h == 0) : (h == 1));
                else
                    eck = ck_pol;
            end else begin
                etx = 1'b1; eck = ck_pol;
            end
            chk((s < 2) ? "R2 start" : (s < 2 + 2 * nb) ? "R2 R4 data" : "R3 stop", tx, etx);
            chk((s >= 2 + 2 * (nb - 1) && s < 2 + 2 * nb) ? "R6 last cell ck" : "R5 ck", ck, eck);
            chk("R9 irq", irq, exp_irq());
            if (s == 0) begin
                chk("R7 txe on load", txe, 1);
                chk("R8 tc low in frame", tc, 0);
            end
            if (s == 2 && has_next)
                chk("R7 txe low after write", txe, 0);
            if (s == 1 && has_next)
                do_write(nxt);
            if (s == total - 1 && has_next)
                chk("R8 no tc before queued frame", tc, 0);
        end
        if (final_idle) begin
            wait_tick();
            chk("R8 tc set", tc, 1);
            chk("R1 idle high", tx, 1);
            chk("R1 idle ck", ck, ck_pol);
            chk("R9 irq idle", irq, (txe_ie || tc_ie) ? 1 : 0);
        end
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        logic [8:0] w1, w2;
        void'($urandom(32'h5eed_0042));
        txe_ie = 1'b1;
        ck_pol = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset tx", tx, 1);
        chk("R1 reset ck", ck, 1);
        chk("R1 reset txe", txe, 1);
        chk("R1 reset tc", tc, 1);
        chk("R9 reset irq", irq, 1);

        // R2 R5: 8 bits, no parity, one stop, pulse in second half, no last pulse
        ck_pol = 1'b0; ck_en = 1'b1; ck_pha = 1'b0; ck_last = 1'b0;
        do_write(9'h0A5);
        run_frame(9'h0A5, 0, 0, 1);

        // R3 R4 R6: 9 bits, odd parity, one and a half stop, inverted pulse first half
        word9 = 1'b1; par_en = 1'b1; par_odd = 1'b1; stop_sel = 2'b01;
        ck_pol = 1'b1; ck_pha = 1'b1; ck_last = 1'b1; tc_ie = 1'b1;
        do_write(9'h137);
        run_frame(9'h137, 0, 0, 1);

        // R4 even parity in 8-bit mode, two stop bits, R8 back-to-back
        word9 = 1'b0; par_odd = 1'b0; stop_sel = 2'b10; ck_en = 1'b0;
        do_write(9'h1FF);
        run_frame(9'h1FF, 1, 9'h081, 0);
        run_frame(9'h081, 0, 0, 1);

        // R10: disabled transmitter holds the word
        tx_en = 1'b0; par_en = 1'b0; stop_sel = 2'b11; txe_ie = 1'b1; tc_ie = 1'b0;
        do_write(9'h03C);
        chk("R8 write clears tc", tc, 0);
        for (int i = 0; i < 6; i++) begin
            wait_tick();
            chk("R10 line high while disabled", tx, 1);
            chk("R10 word pending", txe, 0);
            chk("R9 irq off", irq, 0);
        end
        tx_en = 1'b1;
        run_frame(9'h03C, 0, 0, 1);

        // random frames
        for (int i = 0; i < 40; i++) begin
            word9 = $urandom; par_en = $urandom; par_odd = $urandom;
            stop_sel = $urandom; ck_en = $urandom; ck_pol = $urandom;
            ck_pha = $urandom; ck_last = $urandom;
            txe_ie = $urandom; tc_ie = $urandom;
            w1 = $urandom; w2 = $urandom;
            repeat ($urandom % 5) @(negedge clk);
            do_write(w1);
            if ($urandom % 2) begin
                run_frame(w1, 1, w2, 0);
                run_frame(w2, 0, 0, 1);
            end else begin
                run_frame(w1, 0, 0, 1);
            end
        end
        finish_run();
    end

endmodule